// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

An 8-bit up-counter advances on ticks from a prescaler. The prescaler divides the peripheral clock by one of eight ratios. The same counter serves two roles, chosen by a mode bit. In watchdog mode, a wrap of the counter from 255 to 0 raises a one-cycle reset request. Software is expected to reload the counter before that wrap happens. In interval mode, the same wrap sets a flag that can drive an interrupt request. A periodic tick can be built on this.

Software reaches the block through one write port and one read port, each with a one-bit select. Select 0 chooses the count register and select 1 chooses the control byte. The control byte holds the run bit, the mode, the interrupt enable, the two sticky overflow flags and the clock-select code. Each overflow flag is set only by its own mode. The clock-select code is locked while the timer runs.

Top module: `wdogIntervalTimer`

## Requirements
- R1: After reset the count reads 0, the control byte reads 0x00, and both rstReq and irq are 0.
- R2: The control byte is laid out as follows: bit 7 run, bit 6 mode (1 = watchdog, 0 = interval), bit 5 interrupt enable, bit 4 watchdog flag, bit 3 interval flag, bits 2:0 clock select. Run, mode, enable and select read back as written.
- R3: Clock-select codes 0 to 7 divide the clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. When the timer is started from stopped with code c, the count first increments exactly N(c) cycles after the write edge.
- R4: While run is 0 the count holds its value and the prescaler is held at zero.
- R5: A write with select 0 loads the written byte into the count.
- R6: On a tick at 255 the count wraps to 0 and keeps counting on later ticks.
- R7: The watchdog flag (bit 4) is set by a wrap only in watchdog mode. It is never set in interval mode, and it stays at 1 until software clears it.
- R8: The interval flag (bit 3) is set by a wrap only in interval mode. It is never set in watchdog mode.
- R9: A wrap in watchdog mode drives rstReq high for exactly one cycle, in the cycle after the wrap edge.
- R10: irq is high exactly while the interval flag and the interrupt enable are both 1.
- R11: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves the flag unchanged.
- R12: A control write while run is 1 leaves the clock-select field unchanged. A control write while stopped updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 count, 1 control |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read source: 0 count, 1 control |
| rdData | output | 8 | Combinational read data |
| rstReq | output | 1 | One-cycle reset request on a watchdog wrap |
| irq | output | 1 | Interval interrupt request (level) |

## Verification
Register writes take effect at the clock edge that captures the strobe, and reads are combinational. When the timer is started with ratio N, the first count step lands N edges after the write edge. A wrap updates the count, the flag and rstReq together on that same edge. irq follows the flag with no further delay. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the write edge, so each check falls exactly on the cycle its result is due. For R3 it samples both one edge before and at the step edge.

// File: rtl/wdogPkg.sv
package wdogPkg;
  parameter int CNT_W  = 8;
  parameter int PRE_W  = 12;
  parameter int SEL_W  = 3;
  localparam int NUM_TAPS = 1 << SEL_W;

  // control byte field positions (R2)
  localparam int BIT_RUN  = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_IEN  = 5;
  localparam int BIT_WDF  = 4;
  localparam int BIT_IVF  = 3;

  // prescaler tap exponent per clock-select code (R3)
  function automatic int divShift(input int code);
    case (code)
      0: divShift = 0;
      1: divShift = 2;
      2: divShift = 4;
      3: divShift = 5;
      4: divShift = 6;
      5: divShift = 8;
      6: divShift = 10;
      default: divShift = 12;
    endcase
  endfunction

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] divSel;
    logic             cntLoad;
    logic [CNT_W-1:0] cntVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrlStrobe_t   strb,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [PW-1:0]       pre;
  logic [NUM_TAPS-1:0] tapHit;
  logic                tick;

  // free-running divider, held at zero while stopped (R4)
  always_ff @(posedge clk) begin
    if (rst || !strb.run) pre <= '0;
    else                  pre <= pre + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int SH = divShift(g);
    if (SH == 0) begin : gDirect
      assign tapHit[g] = 1'b1;
    end else begin : gMasked
      assign tapHit[g] = &pre[SH-1:0];
    end
  end

  assign tick = strb.run && tapHit[strb.divSel];
  assign ovf  = tick && (count == {CW{1'b1}}) && !strb.cntLoad;

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (strb.cntLoad) count <= strb.cntVal;
    else if (tick)         count <= count + 1'b1;
  end

  p_count_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!strb.run && !strb.cntLoad) |=> (count == $past(count)));

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (count == '0));
endmodule

// File: rtl/wdogControl.sv
module wdogControl
  import wdogPkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [7:0]    wrData,
  input  logic          rdSel,
  input  logic [CW-1:0] count,
  input  logic          ovf,
  output ctrlStrobe_t   strb,
  output logic [7:0]    rdData,
  output logic          rstReq,
  output logic          irq
);
  logic             runBit, modeWd, irqEn, wdFlag, ivFlag;
  logic [SEL_W-1:0] divSel;
  logic             ctrlWr;
  logic [7:0]       ctrlByte;

  assign ctrlWr = wrEn && wrSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      runBit <= 1'b0;
      modeWd <= 1'b0;
      irqEn  <= 1'b0;
      divSel <= '0;
    end else if (ctrlWr) begin
      runBit <= wrData[BIT_RUN];
      modeWd <= wrData[BIT_MODE];
      irqEn  <= wrData[BIT_IEN];
      if (!runBit) divSel <= wrData[SEL_W-1:0];  // locked while running (R12)
    end
  end

  // sticky flags: overflow sets, written 0 clears, written 1 keeps (R7, R8, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      wdFlag <= 1'b0;
      ivFlag <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= ovf && modeWd;
      if (ovf && modeWd)                  wdFlag <= 1'b1;
      else if (ctrlWr && !wrData[BIT_WDF]) wdFlag <= 1'b0;
      if (ovf && !modeWd)                 ivFlag <= 1'b1;
      else if (ctrlWr && !wrData[BIT_IVF]) ivFlag <= 1'b0;
    end
  end

  always_comb begin
    ctrlByte           = '0;
    ctrlByte[BIT_RUN]  = runBit;
    ctrlByte[BIT_MODE] = modeWd;
    ctrlByte[BIT_IEN]  = irqEn;
    ctrlByte[BIT_WDF]  = wdFlag;
    ctrlByte[BIT_IVF]  = ivFlag;
    ctrlByte[SEL_W-1:0] = divSel;
  end

  assign rdData       = rdSel ? ctrlByte : 8'(count);
  assign irq          = ivFlag && irqEn;
  assign strb.run     = runBit;
  assign strb.divSel  = divSel;
  assign strb.cntLoad = wrEn && !wrSel;
  assign strb.cntVal  = wrData[CW-1:0];

  p_wd_flag_mode_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wdFlag) |-> $past(ovf && modeWd));

  p_iv_flag_mode_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ivFlag) |-> $past(ovf && !modeWd));

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rstReq |=> !rstReq);

  p_sel_locked_r12: assert property (@(posedge clk) disable iff (rst)
    runBit |=> (divSel == $past(divSel)));
endmodule

// File: rtl/wdogIntervalTimer.sv
module wdogIntervalTimer
  import wdogPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       rdSel,
  output logic [7:0] rdData,
  output logic       rstReq,
  output logic       irq
);
  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] count;
  logic             ovf;

  wdogControl #(.CW(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .count(count), .ovf(ovf), .strb(strb),
    .rdData(rdData), .rstReq(rstReq), .irq(irq)
  );

  wdogDatapath #(.CW(CNT_W), .PW(PRE_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .count(count), .ovf(ovf)
  );
endmodule

// File: tb/wdogIntervalTimer_tb_top.sv
module wdogIntervalTimer_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rstReq, irq;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  wdogIntervalTimer dut_i (.clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .rstReq(rstReq), .irq(irq));

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rdSel = sel; #1; v = rdData;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] v;
    rd(0, v); chk("R1", "count", v, 0);
    rd(1, v); chk("R1", "ctrl", v, 0);
    chk("R1", "rstReq", rstReq, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic tLayout();
    logic [7:0] v;
    wr(1, 8'h65); rd(1, v); chk("R2", "ctrl readback", v, 8'h65);
    wr(0, 8'h5A); rd(0, v); chk("R5", "count load", v, 8'h5A);
    edges(10);    rd(0, v); chk("R4", "count held while stopped", v, 8'h5A);
  endtask

  task automatic tDivider(input int code, input int shamt);
    logic [7:0] v;
    int n = 1 << shamt;
    wr(1, 8'h00); wr(0, 8'h00); wr(1, 8'h80 | 8'(code));
    edges(n - 1); rd(0, v); chk("R3", $sformatf("code %0d before step", code), v, 0);
    edges(1);     rd(0, v); chk("R3", $sformatf("code %0d step", code), v, 1);
  endtask

  task automatic tInterval();
    logic [7:0] v;
    wr(1, 8'h00); wr(0, 8'd250); wr(1, 8'hA0);
    edges(3); rd(0, v); chk("R6", "count 253", v, 253); chk("R10", "irq before wrap", irq, 0);
    edges(3); rd(0, v); chk("R6", "wrapped", v, 0);
    rd(1, v); chk("R8", "iv flag set", v[3], 1); chk("R7", "wd flag clear in interval", v[4], 0);
    chk("R10", "irq on", irq, 1); chk("R9", "no rstReq in interval", rstReq, 0);
    edges(1); rd(0, v); chk("R6", "keeps counting", v, 1);
    wr(1, 8'h88); rd(1, v); chk("R11", "write 1 keeps iv flag", v[3], 1);
    chk("R10", "irq gated by enable", irq, 0);
    wr(1, 8'hA0); rd(1, v); chk("R11", "write 0 clears iv flag", v[3], 0);
    chk("R10", "irq off with flag", irq, 0);
    wr(1, 8'h98); rd(1, v); chk("R11", "write 1 does not set", v, 8'h80);
  endtask

  task automatic tWatchdog();
    logic [7:0] v;
    wr(1, 8'h00); wr(0, 8'd254); wr(1, 8'hE0);
    edges(1); chk("R9", "no pulse before wrap", rstReq, 0);
    edges(1); chk("R9", "pulse", rstReq, 1);
    rd(1, v); chk("R7", "wd flag set", v[4], 1); chk("R8", "iv flag clear in wd", v[3], 0);
    chk("R10", "no irq in wd", irq, 0);
    edges(1); chk("R9", "pulse one cycle", rstReq, 0);
    rd(1, v); chk("R7", "wd flag sticky", v[4], 1);
    rd(0, v); chk("R6", "count after wrap", v, 1);
    wr(1, 8'hC0); rd(1, v); chk("R11", "wd flag cleared", v[4], 0);
  endtask

  task automatic tSelLock();
    logic [7:0] v, c0;
    wr(1, 8'h00); wr(0, 8'h00); wr(1, 8'h80);
    wr(1, 8'h87); rd(1, v); chk("R12", "sel held while running", v, 8'h80);
    rd(0, c0); edges(4); rd(0, v); chk("R12", "still divide by 1", v, c0 + 4);
    wr(1, 8'h00); rd(0, c0); edges(20); rd(0, v); chk("R4", "frozen after stop", v, c0);
    wr(1, 8'h03); rd(1, v); chk("R12", "sel written when stopped", v, 8'h03);
  endtask

  initial begin
    edges(3); rst = 1'b0;
    tReset();
    tLayout();
    tDivider(0, 0);  tDivider(1, 2);  tDivider(2, 4);  tDivider(3, 5);
    tDivider(4, 6);  tDivider(5, 8);  tDivider(6, 10); tDivider(7, 12);
    tInterval();
    tWatchdog();
    tSelLock();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule